// File: doc/BRIEF.md
# Masked DRAM Chip-Select Decoder

This block turns a physical address into a DRAM rank select. It holds eight bank registers. Each one carries a 9-bit base, a 9-bit ignore mask, a two-bit addressing mode and an enable. An incoming address is compared in 8 MB units against every bank, with the masked bit positions left out of the compare. The lowest-numbered matching bank drives its chip-select. The mode and index of that bank are passed on to the downstream row/column address multiplexer. The block also reports when no bank matches and when more than one bank matches.

Reset does not set the bank registers to any value; software must program them. Only the per-bank written flags are cleared at reset. A small controller with two states holds every chip-select low until at least one enabled bank has been written:

- QUIET: no live bank exists.
- ARMED: at least one live bank exists.

The transition ARM goes from QUIET to ARMED, and DISARM goes from ARMED back to QUIET. An address is captured on a strobe, and its decode result appears one clock later. The result then holds until the next strobe.

Register layout, one 32-bit word per bank:

| Bits | Content |
|------|---------|
| 31:23 | Base |
| 22:16 | Zero |
| 15:7 | Mask, where bit 7+i ignores compare bit 23+i |
| 6:3 | Zero |
| 2:1 | Mode (01 = mode 1, 10 = mode 2, 00 and 11 reserved) |
| 0 | Enable |

Top module: `csdec_top`

## Requirements
- R1: After reset, all of the following are 0: `cs_o`, `hit_o`, `nohit_o`, `multi_o`, `mode_o` and `bank_o`. Every bank also reads back as 0 until it is written.
- R2: A write stores bits 31:23, 15:7 and 2:0 of `wr_data` into bank `wr_idx`. A read of that bank returns them with bits 22:16 and 6:3 forced to 0.
- R3: A bank matches when address bits 31:23 equal its base. A match sets `cs_o[i]` and `hit_o`.
- R4: Mask bit 7+i set removes address/base bit 23+i from the compare.
- R5: A bank with enable bit 0 clear never matches, whatever its base and mask hold.
- R6: A bank whose mode field is 00 or 11 never matches, even when it is enabled.
- R7: When several banks match, only the lowest-numbered one asserts its chip-select, and `multi_o` is 1. `cs_o` is always one-hot or zero.
- R8: When no bank matches, `cs_o` is 0, `hit_o` is 0 and `nohit_o` is 1.
- R9: The address is captured on a clock edge where `addr_vld` is 1. The outputs change at that edge and hold while `addr_vld` is 0.
- R10: `mode_o` gives the mode field of the selected bank, and `bank_o` gives its index.
- R11: The outputs follow this sequence:
  - A bank that has not been written since reset never matches.
  - While no enabled bank has been written (state QUIET), every strobe gives `nohit_o` = 1.
  - The controller enters ARMED on the clock after such a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bank register write strobe |
| wr_idx | input | 3 | Bank to write |
| wr_data | input | 32 | Bank register write value |
| rd_idx | input | 3 | Bank to read |
| rd_data | output | 32 | Bank register read value (combinational) |
| addr_vld | input | 1 | Address strobe |
| addr | input | 32 | Physical address |
| cs_o | output | 8 | One-hot chip-select |
| mode_o | output | 2 | Mode of the selected bank |
| bank_o | output | 3 | Index of the selected bank |
| hit_o | output | 1 | A bank was selected |
| nohit_o | output | 1 | No bank matched the address |
| multi_o | output | 1 | More than one bank matched |

## Verification
The hardest situation to reach is an overlap: two live banks that both cover one address, where the lower one must win. The bench builds it from two banks with the same base and different modes, so that `mode_o` shows which bank won. It then disables the lower bank and checks that the higher bank takes over and the multiple-hit flag clears. The masked compare is probed with addresses that differ from the base only in ignored bit positions, and with one address that differs in the next bit above them.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
    localparam int NBANK   = 8;
    localparam int IDXW    = $clog2(NBANK);
    localparam int FLDW    = 9;
    localparam int BASE_LO = 23;
    localparam int MASK_LO = 7;

    typedef struct packed {
        logic [FLDW-1:0] base;
        logic [FLDW-1:0] mask;
        logic [1:0]      mode;
        logic            en;
    } bank_t;

    typedef enum logic {ST_QUIET, ST_ARMED} ctl_t;

    function automatic logic mode_ok(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
    import csdec_pkg::*;
#(
    parameter int NB = NBANK,
    localparam int IW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    output bank_t         banks [NB],
    output logic [NB-1:0] written
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written <= '0;
        end else if (wr_en) begin
            written[wr_idx] <= 1'b1;
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IW'(g)) begin
                banks[g].base <= wr_data[BASE_LO +: FLDW];
                banks[g].mask <= wr_data[MASK_LO +: FLDW];
                banks[g].mode <= wr_data[2:1];
                banks[g].en   <= wr_data[0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (written[rd_idx]) begin
            rd_data[BASE_LO +: FLDW] = banks[rd_idx].base;
            rd_data[MASK_LO +: FLDW] = banks[rd_idx].mask;
            rd_data[2:1]             = banks[rd_idx].mode;
            rd_data[0]               = banks[rd_idx].en;
        end
    end
endmodule

// File: rtl/csdec_match.sv
module csdec_match
    import csdec_pkg::*;
#(
    parameter int NB = NBANK
) (
    input  bank_t           banks [NB],
    input  logic [NB-1:0]   written,
    input  logic [FLDW-1:0] afield,
    output logic [NB-1:0]   match,
    output logic [NB-1:0]   live
);
    for (genvar g = 0; g < NB; g++) begin : g_cmp
        assign live[g]  = written[g] && banks[g].en;
        assign match[g] = live[g] && mode_ok(banks[g].mode)
                          && (((afield ^ banks[g].base) & ~banks[g].mask) == '0);
    end
endmodule

// File: rtl/csdec_prio.sv
module csdec_prio #(
    parameter int NB = 8,
    localparam int IW = $clog2(NB)
) (
    input  logic [NB-1:0] req,
    output logic [NB-1:0] grant,
    output logic [IW-1:0] idx,
    output logic          multi
);
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx = IW'(i);
            end
        end
        multi = $countones(req) > 1;
    end
endmodule

// File: rtl/csdec_top.sv
module csdec_top
    import csdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [31:0]      rd_data,
    input  logic             addr_vld,
    input  logic [31:0]      addr,
    output logic [NBANK-1:0] cs_o,
    output logic [1:0]       mode_o,
    output logic [IDXW-1:0]  bank_o,
    output logic             hit_o,
    output logic             nohit_o,
    output logic             multi_o
);
    bank_t            banks [NBANK];
    logic [NBANK-1:0] written, match, live, grant;
    logic [IDXW-1:0]  widx;
    logic             wmulti;
    ctl_t             st_q, st_d;

    csdec_regs #(.NB(NBANK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .banks(banks), .written(written)
    );

    csdec_match #(.NB(NBANK)) u_match (
        .banks(banks), .written(written), .afield(addr[BASE_LO +: FLDW]),
        .match(match), .live(live)
    );

    csdec_prio #(.NB(NBANK)) u_prio (
        .req(match), .grant(grant), .idx(widx), .multi(wmulti)
    );

    // Controller state: ARM when a live bank exists, DISARM when none is left
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUIET: if (|live)  st_d = ST_ARMED;
            ST_ARMED: if (!(|live)) st_d = ST_QUIET;
        endcase
    end

    // Decode results are registered on the address strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_o    <= '0;
            mode_o  <= '0;
            bank_o  <= '0;
            hit_o   <= 1'b0;
            nohit_o <= 1'b0;
            multi_o <= 1'b0;
        end else if (addr_vld) begin
            unique case (st_q)
                ST_QUIET: begin
                    cs_o    <= '0;
                    mode_o  <= '0;
                    bank_o  <= '0;
                    hit_o   <= 1'b0;
                    nohit_o <= 1'b1;
                    multi_o <= 1'b0;
                end
                ST_ARMED: begin
                    cs_o    <= grant;
                    mode_o  <= (|match) ? banks[widx].mode : 2'b00;
                    bank_o  <= widx;
                    hit_o   <= |match;
                    nohit_o <= ~(|match);
                    multi_o <= wmulti;
                end
            endcase
        end
    end
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk
    import csdec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             addr_vld,
    input logic [NBANK-1:0] cs_o,
    input logic [IDXW-1:0]  bank_o,
    input logic             hit_o,
    input logic             nohit_o,
    input logic             multi_o
);
    assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));
    assert_multi_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        multi_o |-> hit_o);
    assert_hit_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && nohit_o));
    assert_cs_vs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_o != '0) == hit_o);
    assert_bank_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> cs_o[bank_o]);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> ($stable(cs_o) && $stable(nohit_o) && $stable(multi_o)));
endmodule

bind csdec_top csdec_chk u_chk (.*);

// File: tb/tb_csdec_top.sv
module tb_csdec_top;
    logic        clk = 0, rst_n = 0, wr_en = 0, addr_vld = 0;
    logic [2:0]  wr_idx = 0, rd_idx = 0, bank_o;
    logic [31:0] wr_data = 0, addr = 0, rd_data;
    logic [7:0]  cs_o;
    logic [1:0]  mode_o;
    logic        hit_o, nohit_o, multi_o;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    csdec_top dut (.*);

    function automatic logic [31:0] mk(input logic [8:0] b, input logic [8:0] m,
                                       input logic [1:0] md, input logic e);
        return {b, 7'b0, m, 4'b0, md, e};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int i, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_idx = 3'(i); wr_data = d;
        @(negedge clk); wr_en = 0;
        @(negedge clk);
    endtask

    task automatic dec(input logic [31:0] a);
        @(negedge clk); addr_vld = 1; addr = a;
        @(negedge clk); addr_vld = 0;
    endtask

    task automatic expect_out(input string req, input logic [7:0] cs, input logic nh,
                              input logic mu, input logic [1:0] md, input logic [2:0] bk);
        chk(req, {24'b0, cs_o}, {24'b0, cs});
        chk(req, {31'b0, hit_o}, {31'b0, cs != 0});
        chk(req, {31'b0, nohit_o}, {31'b0, nh});
        chk(req, {31'b0, multi_o}, {31'b0, mu});
        if (cs != 0) begin
            chk(req, {30'b0, mode_o}, {30'b0, md});
            chk(req, {29'b0, bank_o}, {29'b0, bk});
        end
    endtask

    task automatic t_reset;
        expect_out("R1", 8'h00, 0, 0, 0, 0);
        chk("R1", {30'b0, mode_o}, 0);
        chk("R1", {29'b0, bank_o}, 0);
        rd_idx = 0; #1 chk("R1", rd_data, 32'h0);
        dec(32'h0000_0000);
        expect_out("R11 quiet", 8'h00, 1, 0, 0, 0);
    endtask

    task automatic t_regs;
        wr(3, 32'hFFFF_FFFF);
        rd_idx = 3; #1 chk("R2 reserved zero", rd_data, 32'hFF80_FF87);
        dec(32'hFF80_0000);
        expect_out("R6 mode 11", 8'h00, 1, 0, 0, 0);
        wr(3, 32'h0);
        rd_idx = 4; #1 chk("R11 unwritten reads 0", rd_data, 32'h0);
    endtask

    task automatic t_base;
        wr(2, mk(9'h005, 9'h000, 2'b01, 1));
        dec(32'h0280_0000);
        expect_out("R3 base hit", 8'h04, 0, 0, 2'b01, 3'd2);
        dec(32'h02FF_FFFF);
        expect_out("R3 top of 8MB", 8'h04, 0, 0, 2'b01, 3'd2);
        dec(32'h0300_0000);
        expect_out("R8 miss", 8'h00, 1, 0, 0, 0);
    endtask

    task automatic t_mask;
        wr(2, mk(9'h005, 9'h003, 2'b01, 1));
        dec(32'h0380_0000);
        expect_out("R4 masked bits 23/24", 8'h04, 0, 0, 2'b01, 3'd2);
        dec(32'h0200_0000);
        expect_out("R4 masked low", 8'h04, 0, 0, 2'b01, 3'd2);
        dec(32'h0400_0000);
        expect_out("R4 bit 25 compared", 8'h00, 1, 0, 0, 0);
        wr(2, mk(9'h005, 9'h100, 2'b01, 1));
        dec(32'h8280_0000);
        expect_out("R4 mask bit 15 -> addr bit 31", 8'h04, 0, 0, 2'b01, 3'd2);
    endtask

    task automatic t_enable_mode;
        wr(2, mk(9'h005, 9'h000, 2'b01, 0));
        dec(32'h0280_0000);
        expect_out("R5 disabled", 8'h00, 1, 0, 0, 0);
        wr(2, mk(9'h005, 9'h000, 2'b00, 1));
        dec(32'h0280_0000);
        expect_out("R6 mode 00", 8'h00, 1, 0, 0, 0);
        wr(2, mk(9'h005, 9'h000, 2'b10, 1));
        dec(32'h0280_0000);
        expect_out("R10 mode 2", 8'h04, 0, 0, 2'b10, 3'd2);
    endtask

    task automatic t_prio;
        wr(2, mk(9'h005, 9'h000, 2'b01, 1));
        wr(5, mk(9'h005, 9'h000, 2'b10, 1));
        dec(32'h0280_0000);
        expect_out("R7 lowest wins", 8'h04, 0, 1, 2'b01, 3'd2);
        wr(2, mk(9'h005, 9'h000, 2'b01, 0));
        dec(32'h0280_0000);
        expect_out("R10 bank 5", 8'h20, 0, 0, 2'b10, 3'd5);
    endtask

    task automatic t_latency;
        @(negedge clk); addr_vld = 1; addr = 32'h0300_0000;
        #1 chk("R9 before edge", {24'b0, cs_o}, 32'h20);
        @(negedge clk); addr_vld = 0; addr = 32'h0280_0000;
        chk("R9 after edge", {31'b0, nohit_o}, 1);
        repeat (3) @(negedge clk);
        expect_out("R9 hold", 8'h00, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_base();
        t_mask();
        t_enable_mode();
        t_prio();
        t_latency();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule